// File: doc/BRIEF.md
# Carry-Aware Integer Execution Unit

This block is the integer datapath slice of a small processor pipeline. It takes an operation code, a first operand, a register second operand and a 16-bit immediate, and it returns a 32-bit result with no clock between its inputs and its output. The one piece of state it holds is a carry flag. Add and subtract can read and write that flag, the one-bit right shifts can read and write it, and every other operation leaves it alone.

Each operation code picks its second operand. Some codes take the register operand and others take the immediate, sign-extended to the data width. The add/subtract group spends three opcode bits on three choices: a reverse subtract (second operand minus first), an explicit carry-in taken from the stored flag, and a keep flag that stops the carry from being written. Both compare operations subtract the first operand from the second. When the two operands have different signs, the compare replaces the MSB of the difference, so that the sign of the result gives the signed or the unsigned ordering. The carry flag changes on a rising clock edge, and only when the enable strobe is high and the operation is one that writes the carry.

Top module: `exu_core`

## Requirements
- R1: For opcodes 0x00 to 0x0F, the result is A + Y + cin when opcode bit 0 is clear, and Y + ~A + cin when bit 0 is set. Y is the second operand.
- R2: When opcode bit 1 is clear, cin equals opcode bit 0, so it is 0 for add and 1 for reverse subtract. When bit 1 is set, cin is the stored carry flag.
- R3: When opcode bit 2 is clear in the 0x00 to 0x0F group, an enabled edge loads the carry flag with bit 32 of the 33-bit sum. When bit 2 is set, the carry flag keeps its value.
- R4: When opcode bit 3 is set in the 0x00 to 0x0F group, and for the logic opcodes 0x28 to 0x2B, Y is `imm_i` sign-extended from its bit 15, and `opb_i` has no effect. In all other cases Y is `opb_i`.
- R5: Opcode 0x18 is the signed compare and 0x19 is the unsigned compare. Both produce Y - A. When A[31] and Y[31] differ, result bit 31 is replaced: with Y[31] for the signed compare and with A[31] for the unsigned compare. The carry flag keeps its value.
- R6: Opcodes 0x20 to 0x23 (register form) and 0x28 to 0x2B (immediate form) produce A|Y, A&Y, A^Y and A&~Y, in that order of the low two opcode bits. The carry flag keeps its value.
- R7: Opcodes 0x30, 0x31 and 0x32 shift A right by one bit. The bit entering at position 31 is A[31] for 0x30, the old carry flag for 0x31, and 0 for 0x32. On an enabled edge the carry flag loads A[0].
- R8: Opcode 0x34 copies A[7] into bits 31 to 8 of the result, and opcode 0x35 copies A[15] into bits 31 to 16. The carry flag keeps its value.
- R9: Reset clears the carry flag to 0. While `en_i` is low the carry flag holds its value, whatever the operation code.
- R10: Every opcode not listed above gives a result of 0 and leaves the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Strobe that allows the carry flag to update |
| op_i | input | 6 | Operation code |
| opa_i | input | 32 | First operand A |
| opb_i | input | 32 | Register second operand |
| imm_i | input | 16 | Immediate second operand, sign-extended inside the block |
| res_o | output | 32 | Combinational result |
| carry_o | output | 1 | Stored carry flag |

## Verification
The assertions assume the inputs are stable from the middle of one cycle until the next rising edge. They also assume that `en_i` is only high when an operation really issues, because each carry property compares the flag after the edge with the opcode and operand present at that edge. The bench meets both assumptions: it changes every input on the falling edge and leaves `en_i` high for exactly one edge per operation. Before each table entry it loads a known carry value with a logical shift, so that the carry-in and keep paths start from a known flag.

// File: rtl/exu_pkg.sv
package exu_pkg;
    // Kinds of operation that the decoder can select
    typedef enum logic [2:0] {
        K_ARITH,
        K_CMP,
        K_LOGIC,
        K_SHIFT,
        K_SEXT,
        K_NONE
    } exu_kind_e;

    // Opcodes outside the add/subtract group
    localparam logic [5:0] OP_CMP_S  = 6'h18;
    localparam logic [5:0] OP_CMP_U  = 6'h19;
    localparam logic [5:0] OP_SHR_A  = 6'h30;
    localparam logic [5:0] OP_SHR_C  = 6'h31;
    localparam logic [5:0] OP_SHR_L  = 6'h32;
    localparam logic [5:0] OP_SEXT8  = 6'h34;
    localparam logic [5:0] OP_SEXT16 = 6'h35;

    typedef struct packed {
        exu_kind_e  kind;
        logic       use_imm;
        logic       rev;
        logic       use_c;
        logic       wr_carry;
        logic       cmp_uns;
        logic [1:0] sub;
    } exu_ctrl_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic [OP_W-1:0] op,
    output exu_ctrl_t       ctrl
);
    always_comb begin
        ctrl          = '0;
        ctrl.kind     = K_NONE;
        ctrl.sub      = op[1:0];
        if (op[5:4] == 2'b00) begin
            ctrl.kind     = K_ARITH;
            ctrl.rev      = op[0];
            ctrl.use_c    = op[1];
            ctrl.wr_carry = ~op[2];
            ctrl.use_imm  = op[3];
        end else if (op[5:4] == 2'b10 && op[2] == 1'b0) begin
            ctrl.kind    = K_LOGIC;
            ctrl.use_imm = op[3];
        end else begin
            unique case (op)
                OP_CMP_S, OP_CMP_U: begin
                    ctrl.kind    = K_CMP;
                    ctrl.rev     = 1'b1;
                    ctrl.cmp_uns = op[0];
                end
                OP_SHR_A, OP_SHR_C, OP_SHR_L: begin
                    ctrl.kind     = K_SHIFT;
                    ctrl.wr_carry = 1'b1;
                end
                OP_SEXT8, OP_SEXT16: ctrl.kind = K_SEXT;
                default: ctrl.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/exu_opsel.sv
module exu_opsel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] imm_ext;

    generate
        if (DATA_W > IMM_W) begin : g_ext
            assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    assign y = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/exu_arith.sv
module exu_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] y,
    input  logic              rev,
    input  logic              cin,
    input  logic              cmp_uns,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic [DATA_W-1:0] cmp
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] a_eff;
    logic [DATA_W:0]   wide;

    assign a_eff = rev ? ~a : a;
    assign wide  = {1'b0, a_eff} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    assign sum   = wide[DATA_W-1:0];
    assign cout  = wide[DATA_W];

    // Patch the MSB so that the sign gives the ordering
    always_comb begin
        cmp = sum;
        if (a[MSB] != y[MSB])
            cmp[MSB] = cmp_uns ? a[MSB] : y[MSB];
    end
endmodule

// File: rtl/exu_bitops.sv
module exu_bitops
    import exu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  exu_kind_e         kind,
    input  logic [1:0]        sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] y,
    input  logic              carry_q,
    output logic [DATA_W-1:0] res
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] logic_r, shift_r, sext_r;
    logic              fill;

    always_comb begin
        unique case (sub)
            2'd0: logic_r = a | y;
            2'd1: logic_r = a & y;
            2'd2: logic_r = a ^ y;
            default: logic_r = a & ~y;
        endcase
    end

    always_comb begin
        unique case (sub)
            2'd0: fill = a[MSB];
            2'd1: fill = carry_q;
            default: fill = 1'b0;
        endcase
        shift_r = {fill, a[MSB:1]};
    end

    assign sext_r = sub[0] ? {{(DATA_W-16){a[15]}}, a[15:0]}
                           : {{(DATA_W-8){a[7]}}, a[7:0]};

    always_comb begin
        unique case (kind)
            K_LOGIC: res = logic_r;
            K_SHIFT: res = shift_r;
            K_SEXT:  res = sext_r;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OP_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    exu_ctrl_t         ctrl;
    logic [DATA_W-1:0] y, sum, cmp, bit_res;
    logic              cin, cout, carry_q, carry_nxt;

    exu_decode #(.OP_W(OP_W)) u_dec (
        .op   (op_i),
        .ctrl (ctrl)
    );

    exu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .use_imm (ctrl.use_imm),
        .reg_b   (opb_i),
        .imm     (imm_i),
        .y       (y)
    );

    assign cin = ctrl.use_c ? carry_q : ctrl.rev;

    exu_arith #(.DATA_W(DATA_W)) u_arith (
        .a       (opa_i),
        .y       (y),
        .rev     (ctrl.rev),
        .cin     (cin),
        .cmp_uns (ctrl.cmp_uns),
        .sum     (sum),
        .cout    (cout),
        .cmp     (cmp)
    );

    exu_bitops #(.DATA_W(DATA_W)) u_bits (
        .kind    (ctrl.kind),
        .sub     (ctrl.sub),
        .a       (opa_i),
        .y       (y),
        .carry_q (carry_q),
        .res     (bit_res)
    );

    always_comb begin
        unique case (ctrl.kind)
            K_ARITH: res_o = sum;
            K_CMP:   res_o = cmp;
            default: res_o = bit_res;
        endcase
    end

    assign carry_nxt = (ctrl.kind == K_SHIFT) ? opa_i[0] : cout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (en_i && ctrl.wr_carry)
            carry_q <= carry_nxt;
    end

    assign carry_o = carry_q;
endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk #(
    parameter int DATA_W = 32,
    parameter int OP_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] res_o,
    input logic              carry_o
);
    logic is_keep, is_logic, is_shift, is_cmp, is_sext, is_undef;

    assign is_keep  = (op_i[5:4] == 2'b00) && op_i[2];
    assign is_logic = (op_i[5:4] == 2'b10) && !op_i[2];
    assign is_shift = (op_i == 6'h30) || (op_i == 6'h31) || (op_i == 6'h32);
    assign is_cmp   = (op_i == 6'h18) || (op_i == 6'h19);
    assign is_sext  = (op_i == 6'h34) || (op_i == 6'h35);
    assign is_undef = !(op_i[5:4] == 2'b00) && !is_logic && !is_shift
                      && !is_cmp && !is_sext;

    AST_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && is_keep |=> $stable(carry_o)); // R3
    AST_CMP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && is_cmp |=> $stable(carry_o)); // R5
    AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && is_logic |=> $stable(carry_o)); // R6
    AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && is_shift |=> carry_o == $past(opa_i[0])); // R7
    AST_SEXT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && is_sext |=> $stable(carry_o)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(carry_o)); // R9
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_undef |-> res_o == '0); // R10
    AST_UNDEF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && is_undef |=> $stable(carry_o)); // R10
endmodule

bind exu_core exu_core_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .op_i    (op_i),
    .opa_i   (opa_i),
    .res_o   (res_o),
    .carry_o (carry_o)
);

// File: tb/exu_core_tb_top.sv
module exu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [5:0]  op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] res_o;
    logic        carry_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    exu_core dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .op_i    (op_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .imm_i   (imm_i),
        .res_o   (res_o),
        .carry_o (carry_o)
    );

    // Fields: op, A, B, imm, carry before, expected result, expected carry after
    localparam int NV = 27;
    localparam logic [119:0] VEC [NV] = '{
        {6'h00, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 1'b0, 32'h00000000, 1'b1},
        {6'h01, 32'h00000005, 32'h00000003, 16'h0000, 1'b1, 32'hFFFFFFFE, 1'b0},
        {6'h02, 32'h00000001, 32'h00000002, 16'h0000, 1'b1, 32'h00000004, 1'b0},
        {6'h03, 32'h00000002, 32'h00000007, 16'h0000, 1'b0, 32'h00000004, 1'b1},
        {6'h03, 32'h00000002, 32'h00000007, 16'h0000, 1'b1, 32'h00000005, 1'b1},
        {6'h04, 32'h80000000, 32'h80000000, 16'h0000, 1'b0, 32'h00000000, 1'b0},
        {6'h05, 32'h00000001, 32'h00000001, 16'h0000, 1'b0, 32'h00000000, 1'b0},
        {6'h08, 32'h00000010, 32'h12345678, 16'hFFFF, 1'b0, 32'h0000000F, 1'b1},
        {6'h09, 32'h00000003, 32'h12345678, 16'h0010, 1'b0, 32'h0000000D, 1'b1},
        {6'h0B, 32'h00000002, 32'h00000000, 16'h0007, 1'b1, 32'h00000005, 1'b1},
        {6'h0E, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0000, 1'b1, 32'h80000000, 1'b1},
        {6'h18, 32'h00000001, 32'hFFFFFFFF, 16'h0000, 1'b0, 32'hFFFFFFFE, 1'b0},
        {6'h18, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 1'b1, 32'h00000002, 1'b1},
        {6'h18, 32'h80000000, 32'h7FFFFFFF, 16'h0000, 1'b0, 32'h7FFFFFFF, 1'b0},
        {6'h19, 32'h80000000, 32'h7FFFFFFF, 16'h0000, 1'b1, 32'hFFFFFFFF, 1'b1},
        {6'h19, 32'h00000002, 32'h00000005, 16'h0000, 1'b0, 32'h00000003, 1'b0},
        {6'h20, 32'hF0F00000, 32'h0000FF00, 16'h0000, 1'b1, 32'hF0F0FF00, 1'b1},
        {6'h21, 32'hFF00FF00, 32'h0FF00FF0, 16'h0000, 1'b0, 32'h0F000F00, 1'b0},
        {6'h22, 32'hAAAAAAAA, 32'hFFFF0000, 16'h0000, 1'b1, 32'h5555AAAA, 1'b1},
        {6'h23, 32'hFFFFFFFF, 32'h0000FFFF, 16'h0000, 1'b0, 32'hFFFF0000, 1'b0},
        {6'h28, 32'h00000001, 32'h00000000, 16'h8000, 1'b1, 32'hFFFF8001, 1'b1},
        {6'h2B, 32'h12345678, 32'hFFFFFFFF, 16'h00FF, 1'b0, 32'h12345600, 1'b0},
        {6'h30, 32'h80000003, 32'h00000000, 16'h0000, 1'b0, 32'hC0000001, 1'b1},
        {6'h31, 32'h00000004, 32'h00000000, 16'h0000, 1'b1, 32'h80000002, 1'b0},
        {6'h32, 32'h80000001, 32'h00000000, 16'h0000, 1'b1, 32'h40000000, 1'b1},
        {6'h34, 32'h12345680, 32'h00000000, 16'h0000, 1'b1, 32'hFFFFFF80, 1'b1},
        {6'h35, 32'hABCD7FFF, 32'h00000000, 16'h0000, 1'b0, 32'h00007FFF, 1'b0}
    };

    function automatic string req_of(input logic [5:0] op);
        if (op[5:4] == 2'b00) return op[3] ? "R1/R4" : "R1/R2";
        if (op == 6'h18 || op == 6'h19) return "R5";
        if (op[5:4] == 2'b10) return "R6";
        if (op[5:4] == 2'b11 && !op[2]) return "R7";
        return "R8";
    endfunction

    function automatic string creq_of(input logic [5:0] op);
        if (op[5:4] == 2'b00) return "R3";
        return req_of(op);
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One operation with en_i high for exactly one edge; inputs change on falling edges
    task automatic issue(input logic [5:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] imm);
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; imm_i = imm; en_i = 1'b1;
        @(negedge clk);
        en_i = 1'b0;
    endtask

    task automatic preload(input logic c);
        issue(6'h32, {31'b0, c}, '0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", {31'b0, carry_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", {31'b0, carry_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [119:0] v;
            v = VEC[i];
            preload(v[33]);
            @(negedge clk);
            op_i = v[119:114]; opa_i = v[113:82]; opb_i = v[81:50];
            imm_i = v[49:34]; en_i = 1'b1;
            #2;
            check(req_of(v[119:114]), res_o, v[32:1]);
            @(negedge clk);
            en_i = 1'b0;
            check(creq_of(v[119:114]), {31'b0, carry_o}, {31'b0, v[0]});
        end

        // R4: opb_i has no effect on an immediate-form add
        @(negedge clk);
        op_i = 6'h0C; opa_i = 32'h100; imm_i = 16'h0001; opb_i = 32'hDEADBEEF;
        #2;
        check("R4", res_o, 32'h101);
        opb_i = 32'h00000000;
        #2;
        check("R4", res_o, 32'h101);

        // R9: enable low keeps the flag even when the op would clear it
        preload(1'b1);
        @(negedge clk);
        op_i = 6'h00; opa_i = 32'h0; opb_i = 32'h0; en_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9", {31'b0, carry_o}, 32'h1);

        // R10: undefined opcodes give zero and keep the flag
        issue(6'h3F, 32'h5, 32'h6, 16'h0);
        check("R10", {31'b0, carry_o}, 32'h1);
        @(negedge clk);
        op_i = 6'h1A; opa_i = 32'hFFFF0000; opb_i = 32'h1234;
        #2;
        check("R10", res_o, 32'h0);
        op_i = 6'h24;
        #2;
        check("R10", res_o, 32'h0);
        op_i = 6'h33;
        #2;
        check("R10", res_o, 32'h0);

        // R9: reset in mid-run clears the flag
        preload(1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R9", {31'b0, carry_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule